// File: doc/BRIEF.md
# Bit-Serial Binary Extension Field Multiplier

This block multiplies two elements of GF(2^m) held in polynomial basis. Operand A and the low coefficients of the field polynomial are presented in parallel when a run begins and are captured into registers. Operand B then arrives one bit per clock, highest-order coefficient first. The field polynomial is supplied at run time and is not tied to any trinomial or pentanomial form.

On every clock of a run, the accumulator is multiplied by x and reduced modulo the field polynomial. The result is then summed with the partial product of A and the current B bit. After m clocks the accumulator holds A·B mod f. The result is presented in parallel, and a one-cycle done pulse marks the end of the run.

Each GF(2) sum in the datapath is made from a four-gate NAND network. The datapath therefore contains only NAND and AND cells. Multiplication by x is a one-place left shift, which costs only wiring. The width m is a parameter, with 163 as the default; widths of 233, 283, 409 and 571 are also intended.

Top module: `gf2m_serial_mult`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `prod` is all zeros and `busy` and `done` are low.
- R2: A `start` seen while idle captures `a_in` and `f_in`, clears the accumulator and raises `busy`. In the cycle after that edge, `prod` reads zero.
- R3: B is consumed highest coefficient first. The `b_bit` present at the k-th rising edge after the accepted start is coefficient b[m-k]. After the first such edge, `prod` equals A when b[m-1] is 1, and zero otherwise.
- R4: After a run, `prod` equals A·B reduced modulo x^m + f, where `f_in` bit i is the coefficient of x^i. This holds for any `f_in`, including all-zero operands, a one-valued operand and all-ones operands.
- R5: `busy` stays high for exactly m cycles. The result and `done` appear in the cycle after the m-th update.
- R6: `done` is high for one cycle only.
- R7: While idle, `prod` holds its value until the next accepted start. `b_bit` has no effect while idle.
- R8: A `start` received while `busy` is high is ignored. The run in progress completes with its original operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| a_in | input | M | Parallel operand A |
| f_in | input | M | Field polynomial coefficients x^0..x^(M-1) |
| b_bit | input | 1 | Serial operand B bit, highest coefficient first |
| prod | output | M | Accumulator / product |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when product is valid |

## Verification
The assertions assume that `start` is a single-cycle request and that `b_bit` carries a valid B coefficient on every busy cycle. The stimulus meets both assumptions: it drives all inputs at the falling edge, raises `start` for one cycle, and then shifts out exactly m bits of B. The one deliberate departure is a second `start` pulse injected mid-run, used to show that it is ignored. The operands and the field polynomial are never assumed to be irreducible. Random field vectors and the standard 163-bit pentanomial are both used, because the reduction modulo x^m + f is well defined for any f.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_t;
endpackage

// File: rtl/gf_nand_add.sv
// GF(2) vector sum built from four two-input NAND cells per bit.
module gf_nand_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic n_xy, n_xl, n_yl;
    assign n_xy = ~(x[i] & y[i]);
    assign n_xl = ~(x[i] & n_xy);
    assign n_yl = ~(n_xy & y[i]);
    assign s[i] = ~(n_xl & n_yl);
  end
endmodule

// File: rtl/gf_mac_step.sv
// One iteration: acc*x mod f, then plus bbit*a.
module gf_mac_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] fpoly,
  input  logic         bbit,
  output logic [W-1:0] nxt
);
  logic [W-1:0] shifted, fold, partial, reduced;

  assign shifted = {acc[W-2:0], 1'b0};        // multiply by x: wiring only
  assign fold    = fpoly & {W{acc[W-1]}};     // reduction term
  assign partial = opa & {W{bbit}};           // partial product

  gf_nand_add #(.W(W)) u_reduce (.x(shifted), .y(fold),    .s(reduced));
  gf_nand_add #(.W(W)) u_accum  (.x(reduced), .y(partial), .s(nxt));
endmodule

// File: rtl/gf_run_ctrl.sv
module gf_run_ctrl #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic busy,
  output logic done
);
  import gf2m_pkg::*;
  localparam int CW = $clog2(W);

  run_state_t     state_q;
  logic [CW-1:0]  cnt_q;

  assign busy = (state_q == ST_RUN);
  assign load = start && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (state_q == ST_RUN) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W - 1)) begin
          state_q <= ST_IDLE;
          done    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gf2m_serial_mult.sv
module gf2m_serial_mult #(
  parameter int M = 163
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [M-1:0] a_in,
  input  logic [M-1:0] f_in,
  input  logic         b_bit,
  output logic [M-1:0] prod,
  output logic         busy,
  output logic         done
);
  logic         load;
  logic [M-1:0] opa_q, fpoly_q, acc_q, acc_nxt;

  gf_run_ctrl #(.W(M)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .busy(busy), .done(done)
  );

  gf_mac_step #(.W(M)) u_step (
    .acc(acc_q), .opa(opa_q), .fpoly(fpoly_q), .bbit(b_bit), .nxt(acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opa_q   <= '0;
      fpoly_q <= '0;
      acc_q   <= '0;
    end else if (load) begin
      opa_q   <= a_in;
      fpoly_q <= f_in;
      acc_q   <= '0;
    end else if (busy) begin
      acc_q <= acc_nxt;
    end
  end

  assign prod = acc_q;
endmodule

// File: rtl/gf2m_serial_mult_chk.sv
module gf2m_serial_mult_chk #(
  parameter int M = 163
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [M-1:0] prod
);
  localparam int KW = $clog2(M + 1) + 1;
  logic [KW-1:0] runs_q;

  always_ff @(posedge clk) begin
    if (rst)                runs_q <= '0;
    else if (start && !busy) runs_q <= '0;
    else if (busy)          runs_q <= runs_q + 1'b1;
  end

  p_clear_on_start_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && prod == '0));

  p_run_continues_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && runs_q < KW'(M - 1)) |=> busy);

  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (runs_q == KW'(M)));

  p_done_after_run_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(prod));
endmodule

bind gf2m_serial_mult gf2m_serial_mult_chk #(.M(M)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .prod(prod)
);

// File: tb/test_gf2m_serial_mult.sv
`timescale 1ns/1ps
module test_gf2m_serial_mult;
  localparam int M = 163;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [M-1:0] a_in = '0;
  logic [M-1:0] f_in = '0;
  logic         b_bit = 1'b0;
  logic [M-1:0] prod;
  logic         busy, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  gf2m_serial_mult #(.M(M)) i_gf2m_serial_mult (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .f_in(f_in),
    .b_bit(b_bit), .prod(prod), .busy(busy), .done(done)
  );

  function automatic logic [M-1:0] ref_mul(logic [M-1:0] a, logic [M-1:0] b,
                                           logic [M-1:0] f);
    logic [2*M-1:0] p = '0;
    for (int i = 0; i < M; i++)
      if (b[i]) p ^= ({{M{1'b0}}, a} << i);
    for (int i = 2*M-2; i >= M; i--)
      if (p[i]) begin
        p[i] = 1'b0;
        p ^= ({{M{1'b0}}, f} << (i - M));
      end
    return p[M-1:0];
  endfunction

  function automatic logic [M-1:0] rand_vec();
    logic [M-1:0] v = '0;
    for (int i = 0; i < (M + 31) / 32; i++) v = (v << 32) | M'($urandom());
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [M-1:0] act, logic [M-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inj >= 0: pulse start (with altered a_in) after that many bits
  task automatic run(logic [M-1:0] a, logic [M-1:0] b, logic [M-1:0] f, int inj);
    logic [M-1:0] exp = ref_mul(a, b, f);
    bit busy_ok = 1;
    @(negedge clk);
    a_in = a; f_in = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a_in = rand_vec();
    check(busy && prod == '0, "R2 cleared on start", prod, '0);
    for (int i = M - 1; i >= 0; i--) begin
      b_bit = b[i];
      if (inj >= 0 && (M - 1 - i) == inj) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (i == M - 1)
        check(prod == (b[M-1] ? a : '0), "R3 first bit is b[m-1]", prod, b[M-1] ? a : '0);
      if (i > 0 && !busy) busy_ok = 0;
    end
    check(busy_ok, "R5 busy held for m cycles", {{(M-1){1'b0}}, busy_ok}, 1);
    check(done && !busy, "R5 done after m updates", {{(M-1){1'b0}}, done}, 1);
    check(prod == exp, inj >= 0 ? "R8 start while busy ignored" : "R4 product", prod, exp);
    b_bit = ~b_bit;
    @(negedge clk);
    check(!done, "R6 done single cycle", {{(M-1){1'b0}}, done}, 0);
    for (int k = 0; k < 3; k++) begin
      b_bit = $urandom() & 1;
      @(negedge clk);
    end
    check(prod == exp, "R7 hold while idle", prod, exp);
  endtask

  initial begin
    logic [M-1:0] fpent, ones;
    void'($urandom(32'd2024));
    fpent = '0;
    fpent[7] = 1'b1; fpent[6] = 1'b1; fpent[3] = 1'b1; fpent[0] = 1'b1;
    ones = '1;
    repeat (3) @(negedge clk);
    check(prod == '0 && !busy && !done, "R1 reset state", prod, '0);
    rst = 1'b0;
    @(negedge clk);
    check(prod == '0 && !busy && !done, "R1 after release", prod, '0);

    // directed corners (R4)
    run('0, rand_vec(), fpent, -1);
    run(rand_vec(), '0, fpent, -1);
    run(M'(1), rand_vec(), fpent, -1);
    run(rand_vec(), M'(1), fpent, -1);
    run(ones, ones, fpent, -1);
    // R3 probe: only the top coefficient of B set, A = 1
    run(M'(1), {1'b1, {(M-1){1'b0}}}, fpent, -1);
    // random operands, standard pentanomial
    for (int n = 0; n < 12; n++) run(rand_vec(), rand_vec(), fpent, -1);
    // random field vectors (generic reduction, R4)
    for (int n = 0; n < 4; n++) run(rand_vec(), rand_vec(), rand_vec(), -1);
    // R8: start injected mid-run
    run(rand_vec(), rand_vec(), fpent, 40);
    run(rand_vec(), rand_vec(), fpent, M - 2);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule